// File: doc/BRIEF.md
# Fixed-Priority Shared Bus Interconnect

This block joins three bus masters to up to sixteen memory-mapped slaves over one shared path. The three masters are a debug access port, a serial program loader and the core's load/store unit. Each master drives a request, a 32-bit address, write data and a write enable. In any cycle one master at most owns the bus. The owner is picked combinationally by fixed rank: debug port first, then the loader, then the core.

The four highest address bits of the owner name the target slave. The remaining offset bits and the write data go out on a path that all slaves share. Only the addressed slave receives a write strobe, and only when the owner is writing. The addressed slave's read data goes back to the owning master alone; the other masters read zero.

The core also gets a hold signal for its pipeline. It rises while the loader owns the bus, and whenever the core asks for the bus without getting it.

The owner choice is held as a named enumerated state (`OWN_NONE`, `OWN_DBG`, `OWN_LDR`, `OWN_CORE`) and is re-evaluated every cycle from the requests. It moves to `OWN_DBG` whenever the debug request is high. It moves to `OWN_LDR` when the loader asks and the debug port does not. It moves to `OWN_CORE` when only the core asks, and falls back to `OWN_NONE` when nobody asks.

Top module: `bus_interconnect`

## Requirements
- R1: Ownership follows fixed rank: a debug request wins over all others, a loader request wins over the core, and the grant vector `m_gnt` (bit 0 debug, bit 1 loader, bit 2 core) has at most one bit set and only for a requesting master.
- R2: The target slave index is address bits [31:28] of the owning master, and `s_addr` carries that master's address bits [27:0] unchanged.
- R3: `s_we` bit k is high only when the owner is writing and its slave index equals k; at most one bit of `s_we` is set, and a read by the owner sets none.
- R4: With no request active, `m_gnt` is zero, `s_we` is zero, and `s_addr` and `s_wdata` are zero.
- R5: The owning master's read-data output carries the selected slave's word from `s_rdata` (slave k at bits [32k+31:32k]); every non-owning master's read data is zero.
- R6: `core_hold` is high whenever the loader owns the bus, even with no core request.
- R7: `core_hold` is high whenever the core requests and is not the owner.
- R8: `core_hold` is low when the core owns the bus, and also when the loader does not own the bus and the core is not requesting.
- R9: `s_wdata` carries the owning master's write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dbg_req | input | 1 | Debug port requests the bus |
| dbg_we | input | 1 | Debug port write strobe |
| dbg_addr | input | 32 | Debug port address |
| dbg_wdata | input | 32 | Debug port write data |
| dbg_rdata | output | 32 | Read data returned to debug port |
| ldr_req | input | 1 | Program loader requests the bus |
| ldr_we | input | 1 | Program loader write strobe |
| ldr_addr | input | 32 | Program loader address |
| ldr_wdata | input | 32 | Program loader write data |
| ldr_rdata | output | 32 | Read data returned to program loader |
| core_req | input | 1 | Core load/store requests the bus |
| core_we | input | 1 | Core write strobe |
| core_addr | input | 32 | Core address |
| core_wdata | input | 32 | Core write data |
| core_rdata | output | 32 | Read data returned to core |
| core_hold | output | 1 | Pipeline hold request to the core |
| m_gnt | output | 3 | One-hot owner: bit 0 debug, bit 1 loader, bit 2 core |
| s_addr | output | 28 | Offset address shared by all slaves |
| s_wdata | output | 32 | Write data shared by all slaves |
| s_we | output | 16 | Per-slave write strobe |
| s_rdata | input | 512 | Read words of all slaves, slave k at [32k+31:32k] |

## Verification
Two functions can coincide in one cycle: losing the bus and holding the pipeline. The bench provokes this with a core write to one slave while the loader, or the debug port, writes to another. In that cycle it checks that the core's slave sees no strobe and that only the winner's slave does. It also checks that `core_hold` is high and that the core's read data is zero while the winner gets its slave's word. A separate case raises the loader request with the core idle, so that a hold with no contention is judged on its own.

// File: rtl/bus_ic_pkg.sv
package bus_ic_pkg;

    typedef enum logic [1:0] {
        OWN_NONE,
        OWN_DBG,
        OWN_LDR,
        OWN_CORE
    } owner_e;

    localparam int NUM_MASTERS = 3;
    localparam int M_DBG  = 0;
    localparam int M_LDR  = 1;
    localparam int M_CORE = 2;

endpackage

// File: rtl/bus_arbiter.sv
module bus_arbiter
    import bus_ic_pkg::*;
(
    input  logic [NUM_MASTERS-1:0] req,
    output owner_e                 owner,
    output logic [NUM_MASTERS-1:0] gnt
);

    // owner selection: fixed rank, debug > loader > core
    always_comb begin
        if (req[M_DBG])
            owner = OWN_DBG;
        else if (req[M_LDR])
            owner = OWN_LDR;
        else if (req[M_CORE])
            owner = OWN_CORE;
        else
            owner = OWN_NONE;
    end

    // grant outputs from owner state
    always_comb begin
        gnt = '0;
        unique case (owner)
            OWN_DBG:  gnt[M_DBG]  = 1'b1;
            OWN_LDR:  gnt[M_LDR]  = 1'b1;
            OWN_CORE: gnt[M_CORE] = 1'b1;
            OWN_NONE: gnt = '0;
            default:  gnt = '0;
        endcase
    end

    always_comb begin
        a_r1_grant_only_requester: assert ((gnt & ~req) == '0);
        a_r1_grant_when_asked: assert ((req == '0) || (gnt != '0));
    end

endmodule

// File: rtl/bus_slave_decode.sv
module bus_slave_decode #(
    parameter int SEL_W = 4,
    localparam int NUM_SLAVES = 1 << SEL_W
) (
    input  logic [SEL_W-1:0]      idx,
    input  logic                  en,
    output logic [NUM_SLAVES-1:0] hit
);

    for (genvar k = 0; k < NUM_SLAVES; k++) begin : g_hit
        assign hit[k] = en && (idx == SEL_W'(k));
    end

    always_comb begin
        a_r3_single_strobe: assert ($countones(hit) <= 1);
        a_r3_strobe_needs_enable: assert (en || (hit == '0));
    end

endmodule

// File: rtl/bus_interconnect.sv
module bus_interconnect
    import bus_ic_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int SEL_W  = 4,
    localparam int NUM_SLAVES = 1 << SEL_W,
    localparam int OFF_W      = ADDR_W - SEL_W
) (
    input  logic                         dbg_req,
    input  logic                         dbg_we,
    input  logic [ADDR_W-1:0]            dbg_addr,
    input  logic [DATA_W-1:0]            dbg_wdata,
    output logic [DATA_W-1:0]            dbg_rdata,
    input  logic                         ldr_req,
    input  logic                         ldr_we,
    input  logic [ADDR_W-1:0]            ldr_addr,
    input  logic [DATA_W-1:0]            ldr_wdata,
    output logic [DATA_W-1:0]            ldr_rdata,
    input  logic                         core_req,
    input  logic                         core_we,
    input  logic [ADDR_W-1:0]            core_addr,
    input  logic [DATA_W-1:0]            core_wdata,
    output logic [DATA_W-1:0]            core_rdata,
    output logic                         core_hold,
    output logic [NUM_MASTERS-1:0]       m_gnt,
    output logic [OFF_W-1:0]             s_addr,
    output logic [DATA_W-1:0]            s_wdata,
    output logic [NUM_SLAVES-1:0]        s_we,
    input  logic [NUM_SLAVES*DATA_W-1:0] s_rdata
);

    owner_e            owner;
    logic              bus_active;
    logic              bus_we;
    logic [ADDR_W-1:0] bus_addr;
    logic [DATA_W-1:0] bus_wdata;
    logic [SEL_W-1:0]  sel_idx;
    logic [DATA_W-1:0] rd_words [NUM_SLAVES];
    logic [DATA_W-1:0] rd_sel;

    bus_arbiter i_arb (
        .req   ({core_req, ldr_req, dbg_req}),
        .owner (owner),
        .gnt   (m_gnt)
    );

    // path mux from owner state
    always_comb begin
        bus_active = 1'b1;
        unique case (owner)
            OWN_DBG: begin
                bus_we = dbg_we;  bus_addr = dbg_addr;  bus_wdata = dbg_wdata;
            end
            OWN_LDR: begin
                bus_we = ldr_we;  bus_addr = ldr_addr;  bus_wdata = ldr_wdata;
            end
            OWN_CORE: begin
                bus_we = core_we; bus_addr = core_addr; bus_wdata = core_wdata;
            end
            default: begin
                bus_active = 1'b0;
                bus_we = 1'b0;    bus_addr = '0;        bus_wdata = '0;
            end
        endcase
    end

    assign sel_idx = bus_addr[ADDR_W-1 -: SEL_W];
    assign s_addr  = bus_addr[OFF_W-1:0];
    assign s_wdata = bus_wdata;

    bus_slave_decode #(.SEL_W(SEL_W)) i_dec (
        .idx (sel_idx),
        .en  (bus_active && bus_we),
        .hit (s_we)
    );

    for (genvar k = 0; k < NUM_SLAVES; k++) begin : g_rd
        assign rd_words[k] = s_rdata[k*DATA_W +: DATA_W];
    end
    assign rd_sel = rd_words[sel_idx];

    assign dbg_rdata  = m_gnt[M_DBG]  ? rd_sel : '0;
    assign ldr_rdata  = m_gnt[M_LDR]  ? rd_sel : '0;
    assign core_rdata = m_gnt[M_CORE] ? rd_sel : '0;

    assign core_hold = m_gnt[M_LDR] || (core_req && !m_gnt[M_CORE]);

    always_comb begin
        a_r1_onehot_grant: assert ($onehot0(m_gnt));
        a_r4_idle_no_write: assert (dbg_req || ldr_req || core_req || (s_we == '0));
        a_r7_hold_on_loss: assert (!core_req || m_gnt[M_CORE] || core_hold);
        a_r8_no_hold_when_owner: assert (!m_gnt[M_CORE] || !core_hold);
        a_r5_core_zero_when_loser: assert (m_gnt[M_CORE] || (core_rdata == '0));
    end

endmodule

// File: tb/test_bus_interconnect.sv
`timescale 1ns/1ps
module test_bus_interconnect;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic        dbg_req, dbg_we, ldr_req, ldr_we, core_req, core_we;
    logic [31:0] dbg_addr, dbg_wdata, ldr_addr, ldr_wdata, core_addr, core_wdata;
    logic [31:0] dbg_rdata, ldr_rdata, core_rdata;
    logic        core_hold;
    logic [2:0]  m_gnt;
    logic [27:0] s_addr;
    logic [31:0] s_wdata;
    logic [15:0] s_we;
    logic [511:0] s_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    bus_interconnect i_bus_interconnect (
        .dbg_req(dbg_req), .dbg_we(dbg_we), .dbg_addr(dbg_addr),
        .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata),
        .ldr_req(ldr_req), .ldr_we(ldr_we), .ldr_addr(ldr_addr),
        .ldr_wdata(ldr_wdata), .ldr_rdata(ldr_rdata),
        .core_req(core_req), .core_we(core_we), .core_addr(core_addr),
        .core_wdata(core_wdata), .core_rdata(core_rdata),
        .core_hold(core_hold), .m_gnt(m_gnt), .s_addr(s_addr),
        .s_wdata(s_wdata), .s_we(s_we), .s_rdata(s_rdata)
    );

    function automatic logic [31:0] slave_word(int k);
        return 32'hC0DE_0000 | (32'(k) * 32'h111);
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle_all();
        dbg_req = 0;  dbg_we = 0;  dbg_addr = '0;  dbg_wdata = '0;
        ldr_req = 0;  ldr_we = 0;  ldr_addr = '0;  ldr_wdata = '0;
        core_req = 0; core_we = 0; core_addr = '0; core_wdata = '0;
    endtask

    task automatic settle();
        @(negedge clk);
        #1;
    endtask

    task automatic t_idle();
        idle_all(); settle();
        chk("R4 gnt", 64'(m_gnt), 0);
        chk("R4 we", 64'(s_we), 0);
        chk("R4 addr", 64'(s_addr), 0);
        chk("R4 wdata", 64'(s_wdata), 0);
        chk("R8 hold idle", 64'(core_hold), 0);
        chk("R5 core rdata idle", 64'(core_rdata), 0);
    endtask

    task automatic t_core_write();
        idle_all();
        core_req = 1; core_we = 1; core_addr = 32'h3000_0040; core_wdata = 32'h1234_5678;
        settle();
        chk("R1 core gnt", 64'(m_gnt), 3'b100);
        chk("R3 core we", 64'(s_we), 16'h0008);
        chk("R2 offset", 64'(s_addr), 28'h000_0040);
        chk("R9 wdata", 64'(s_wdata), 32'h1234_5678);
        chk("R8 hold owner", 64'(core_hold), 0);
        chk("R5 core rdata", 64'(core_rdata), 64'(slave_word(3)));
    endtask

    task automatic t_core_read();
        idle_all();
        core_req = 1; core_addr = 32'hF123_4567;
        settle();
        chk("R3 read no we", 64'(s_we), 0);
        chk("R2 read offset", 64'(s_addr), 28'h123_4567);
        chk("R5 read slave15", 64'(core_rdata), 64'(slave_word(15)));
        chk("R5 dbg zero", 64'(dbg_rdata), 0);
    endtask

    task automatic t_ldr_over_core();
        idle_all();
        ldr_req = 1;  ldr_we = 1;  ldr_addr = 32'h5000_0010;  ldr_wdata = 32'hAAAA_5555;
        core_req = 1; core_we = 1; core_addr = 32'h3000_0020; core_wdata = 32'h0BAD_0BAD;
        settle();
        chk("R1 ldr wins", 64'(m_gnt), 3'b010);
        chk("R3 ldr we only", 64'(s_we), 16'h0020);
        chk("R9 ldr wdata", 64'(s_wdata), 32'hAAAA_5555);
        chk("R7 hold on loss", 64'(core_hold), 1);
        chk("R5 core zero", 64'(core_rdata), 0);
        chk("R5 ldr rdata", 64'(ldr_rdata), 64'(slave_word(5)));
    endtask

    task automatic t_ldr_alone();
        idle_all();
        ldr_req = 1; ldr_addr = 32'h7000_0000;
        settle();
        chk("R6 hold on download", 64'(core_hold), 1);
        chk("R3 ldr read no we", 64'(s_we), 0);
        chk("R5 ldr read", 64'(ldr_rdata), 64'(slave_word(7)));
    endtask

    task automatic t_dbg_top();
        idle_all();
        dbg_req = 1;  dbg_we = 1;  dbg_addr = 32'h0000_0008; dbg_wdata = 32'hDEAD_BEEF;
        ldr_req = 1;  ldr_we = 1;  ldr_addr = 32'h5000_0000;
        core_req = 1; core_we = 1; core_addr = 32'h3000_0000;
        settle();
        chk("R1 dbg wins", 64'(m_gnt), 3'b001);
        chk("R3 dbg we", 64'(s_we), 16'h0001);
        chk("R2 dbg offset", 64'(s_addr), 28'h000_0008);
        chk("R7 hold core lost to dbg", 64'(core_hold), 1);
        chk("R5 ldr zero", 64'(ldr_rdata), 0);
        chk("R5 dbg rdata", 64'(dbg_rdata), 64'(slave_word(0)));
    endtask

    task automatic t_dbg_core_idle();
        idle_all();
        dbg_req = 1; dbg_addr = 32'h9000_0000;
        settle();
        chk("R8 no hold dbg only", 64'(core_hold), 0);
        chk("R5 dbg read slave9", 64'(dbg_rdata), 64'(slave_word(9)));
    endtask

    task automatic t_sweep();
        for (int k = 0; k < 16; k++) begin
            idle_all();
            core_req = 1; core_we = 1;
            core_addr = {4'(k), 28'h0AB_CDEF};
            settle();
            chk("R2 R3 sweep we", 64'(s_we), 64'(16'h1 << k));
            chk("R2 sweep offset", 64'(s_addr), 28'h0AB_CDEF);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        for (int k = 0; k < 16; k++) s_rdata[k*32 +: 32] = slave_word(k);
        idle_all();
        repeat (3) @(posedge clk);
        rst = 1'b0;
        t_idle();
        t_core_write();
        t_core_read();
        t_ldr_over_core();
        t_ldr_alone();
        t_dbg_top();
        t_dbg_core_idle();
        t_sweep();
        finish_run();
    end

    initial begin
        #50000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule